// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block turns a single command word into a complete I2C master transaction. The command word holds a 3-bit opcode and a set of parameter flags. The opcode selects one of six transaction types: write, read, write followed by read, address probe, bus clear, or a lone STOP. The flags give the 7-bit target address and choose four per-command options: keep the bus after the last byte instead of releasing it, skip the address byte, carry on after an address NACK, and acknowledge the final read byte.

The sequencer does not drive SCL or SDA itself. It issues byte-level bus operations to an external bit engine through a request/done handshake: START, STOP, WRITE byte, READ byte, and CLEAR (nine clocks with SDA released). Write data is pulled from a ready/valid byte stream. Read data is pushed out as one-cycle strobes. Results are reported through five sticky status bits, each cleared by writing a one.

Top module: `i2c_cmd_seq`

## Requirements
- R1: The opcode is `cmd_word[18:16]`. The legal values are 1 write, 2 read, 3 write-then-read, 4 address only, 6 bus clear and 7 STOP. Opcodes 0 and 5 set status bit 3 (illegal command), issue no bus operation and do not set command done.
- R2: Bus operation codes are 0 START, 1 STOP, 2 WRITE, 3 READ and 4 CLEAR. A write issues START, then the address byte `{cmd_word[15:9],0}`, then `tx_len` bytes taken in order from the TX stream, then STOP. `bus_req` holds `bus_op`/`bus_wbyte` steady until `bus_done`.
- R3: A read issues START, then `{addr,1}`, then `rx_len` READ operations. `bus_ack`=1 on every READ except the last, which has `bus_ack`=0 unless `cmd_word[7]` is set. Every byte read appears once on `rx_data` with `rx_valid`.
- R4: Write-then-read issues the write part, then a repeated START and `{addr,1}`, then the read part, with no STOP in between.
- R5: Address only issues START, `{addr,0}` and STOP.
- R6: With `cmd_word[2]` set, the final STOP is left out. Command done is set once the last operation completes. The next command opens with START.
- R7: With `cmd_word[8]` set, every address byte is left out of the sequence.
- R8: A NACK on an address byte sets status bit 2 (failure) and goes straight to STOP, unless `cmd_word[6]` is set, in which case the transaction continues. A NACK on a data byte always sets failure and goes to STOP.
- R9: Bus clear issues CLEAR then STOP, even when bit 2 is set. Opcode 7 issues only STOP.
- R10: An `abort_req` pulse during a command lets the current operation finish, then issues STOP and sets status bit 1 (abort done) instead of command done.
- R11: A `cmd_valid` pulse while busy is dropped and sets status bit 4 (overrun). The running command is not disturbed.
- R12: Status bits are bit 0 done, bit 1 abort done, bit 2 failure, bit 3 illegal and bit 4 overrun. They reset to 0, stay set, and clear only where `sts_clr` carries a one.
- R13: Command done is raised exactly once for each legal command that is not aborted, including commands that end in failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | CMD_W | Opcode [18:16] and parameter flags [15:0] |
| tx_len | input | LEN_W | Bytes to write, sampled with the command |
| rx_len | input | LEN_W | Bytes to read, sampled with the command |
| tx_valid | input | 1 | TX stream byte available |
| tx_data | input | 8 | TX stream byte |
| tx_ready | output | 1 | TX byte taken this cycle when valid |
| rx_valid | output | 1 | RX byte strobe |
| rx_data | output | 8 | RX byte |
| abort_req | input | 1 | Abort the running command |
| bus_req | output | 1 | Bus operation requested |
| bus_op | output | 3 | Bus operation code |
| bus_wbyte | output | 8 | Byte to write |
| bus_ack | output | 1 | Acknowledge to send after a READ |
| bus_done | input | 1 | Bus operation complete |
| bus_rbyte | input | 8 | Byte read by the bit engine |
| bus_nack | input | 1 | Target did not acknowledge the written byte |
| sts_clr | input | 5 | Write-one-to-clear status mask |
| sts | output | 5 | Sticky status bits |
| busy | output | 1 | A command is in progress |

## Verification
The bench builds the block with `LEN_W`=4. This makes a full-length 15-byte write a short run and keeps the byte counters' wrap close to the tested values. `CMD_W` stays at 19, so every flag position and opcode value is driven as the requirements place it. A behavioural responder records every bus operation and compares the list with one built from the requirements. It answers with chosen NACK and abort points, which reach the failure, ignore-NACK and abort paths at exact positions in the sequence.

// File: rtl/i2c_cmd_seq_pkg.sv
package i2c_cmd_seq_pkg;

   typedef enum logic [2:0] {
      BOP_START = 3'd0,
      BOP_STOP  = 3'd1,
      BOP_WRITE = 3'd2,
      BOP_READ  = 3'd3,
      BOP_CLEAR = 3'd4
   } bus_op_e;

   localparam logic [2:0] OPC_WR   = 3'd1;
   localparam logic [2:0] OPC_RD   = 3'd2;
   localparam logic [2:0] OPC_WRRD = 3'd3;
   localparam logic [2:0] OPC_ADDR = 3'd4;
   localparam logic [2:0] OPC_CLR  = 3'd6;
   localparam logic [2:0] OPC_STOP = 3'd7;

   localparam int OPC_LSB     = 16;
   localparam int FLG_HOLD    = 2;
   localparam int FLG_IGNNACK = 6;
   localparam int FLG_ACKLAST = 7;
   localparam int FLG_NOADDR  = 8;
   localparam int ADDR_LSB    = 9;

   localparam int ST_DONE = 0;
   localparam int ST_ABT  = 1;
   localparam int ST_FAIL = 2;
   localparam int ST_ILL  = 3;
   localparam int ST_OVR  = 4;
   localparam int ST_N    = 5;

   typedef enum logic [3:0] {
      PH_CLR  = 4'd0,
      PH_S1   = 4'd1,
      PH_A1   = 4'd2,
      PH_WD   = 4'd3,
      PH_S2   = 4'd4,
      PH_A2   = 4'd5,
      PH_RD   = 4'd6,
      PH_STOP = 4'd7,
      PH_END  = 4'd8
   } phase_e;

   typedef enum logic [1:0] {
      SQ_IDLE, SQ_DECIDE, SQ_FETCH, SQ_REQ
   } seq_st_e;

endpackage

// File: rtl/i2c_cmd_sticky.sv
module i2c_cmd_sticky #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (set[i]) q[i] <= 1'b1;
         else if (clr[i]) q[i] <= 1'b0;
      end

      // R12: a set bit survives any cycle without a clear
      p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (q[i] && !clr[i]) |=> q[i]);
   end
endmodule

// File: rtl/i2c_cmd_fsm.sv
module i2c_cmd_fsm
   import i2c_cmd_seq_pkg::*;
#(
   parameter int LEN_W = 8,
   parameter int CMD_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd_word,
   input  logic [LEN_W-1:0] tx_len,
   input  logic [LEN_W-1:0] rx_len,
   input  logic             tx_valid,
   input  logic [7:0]       tx_data,
   output logic             tx_ready,
   output logic             rx_valid,
   output logic [7:0]       rx_data,
   input  logic             abort_req,
   output logic             bus_req,
   output logic [2:0]       bus_op,
   output logic [7:0]       bus_wbyte,
   output logic             bus_ack,
   input  logic             bus_done,
   input  logic [7:0]       bus_rbyte,
   input  logic             bus_nack,
   output logic             busy,
   output logic [ST_N-1:0]  evt
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   seq_st_e          st;
   phase_e           ph;
   logic [2:0]       opc;
   logic [6:0]       addr;
   logic             f_hold, f_ign, f_acklast, f_noaddr;
   logic [LEN_W-1:0] wcnt, rcnt;
   logic             failing, aborting, abort_lat;
   bus_op_e          op_r;
   logic [7:0]       wbyte_r;
   logic             ack_r;

   logic [2:0] in_opc;
   logic       in_legal;
   assign in_opc   = cmd_word[OPC_LSB +: 3];
   assign in_legal = (in_opc != 3'd0) && (in_opc != 3'd5);

   logic    is_xfer, has_wr, has_rd;
   logic    d_use, d_ack;
   bus_op_e d_op;
   logic [7:0] d_byte;

   assign is_xfer = (opc >= OPC_WR) && (opc <= OPC_ADDR);
   assign has_wr  = (opc == OPC_WR) || (opc == OPC_WRRD);
   assign has_rd  = (opc == OPC_RD) || (opc == OPC_WRRD);

   always_comb begin
      d_use  = 1'b0;
      d_op   = BOP_START;
      d_byte = 8'h00;
      d_ack  = 1'b0;
      case (ph)
         PH_CLR:  begin d_use = (opc == OPC_CLR); d_op = BOP_CLEAR; end
         PH_S1:   d_use = is_xfer;
         PH_A1:   begin
            d_use = is_xfer && !f_noaddr; d_op = BOP_WRITE;
            d_byte = {addr, opc == OPC_RD};
         end
         PH_WD:   d_use = has_wr && (wcnt != '0);
         PH_S2:   d_use = (opc == OPC_WRRD);
         PH_A2:   begin
            d_use = (opc == OPC_WRRD) && !f_noaddr; d_op = BOP_WRITE;
            d_byte = {addr, 1'b1};
         end
         PH_RD:   begin
            d_use = has_rd && (rcnt != '0); d_op = BOP_READ;
            d_ack = (rcnt != ONE) || f_acklast;
         end
         PH_STOP: begin
            d_use = (opc == OPC_CLR) || (opc == OPC_STOP) || !f_hold
                    || failing || aborting;
            d_op  = BOP_STOP;
         end
         default: d_use = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SQ_IDLE; ph <= PH_CLR; opc <= '0; addr <= '0;
         f_hold <= 1'b0; f_ign <= 1'b0; f_acklast <= 1'b0; f_noaddr <= 1'b0;
         wcnt <= '0; rcnt <= '0;
         failing <= 1'b0; aborting <= 1'b0; abort_lat <= 1'b0;
         op_r <= BOP_START; wbyte_r <= '0; ack_r <= 1'b0;
         evt <= '0; rx_valid <= 1'b0; rx_data <= '0;
      end else begin
         evt      <= '0;
         rx_valid <= 1'b0;
         if (cmd_valid && st != SQ_IDLE) evt[ST_OVR] <= 1'b1;
         if (abort_req && st != SQ_IDLE) abort_lat <= 1'b1;
         case (st)
            SQ_IDLE: if (cmd_valid) begin
               if (in_legal) begin
                  opc <= in_opc; addr <= cmd_word[ADDR_LSB +: 7];
                  f_hold <= cmd_word[FLG_HOLD]; f_ign <= cmd_word[FLG_IGNNACK];
                  f_acklast <= cmd_word[FLG_ACKLAST]; f_noaddr <= cmd_word[FLG_NOADDR];
                  wcnt <= tx_len; rcnt <= rx_len; ph <= PH_CLR;
                  failing <= 1'b0; aborting <= 1'b0; abort_lat <= 1'b0;
                  st <= SQ_DECIDE;
               end else begin
                  evt[ST_ILL] <= 1'b1;
               end
            end
            SQ_DECIDE: begin
               if (abort_lat && !aborting && ph < PH_STOP) begin
                  aborting <= 1'b1;
                  ph       <= PH_STOP;
               end else if (ph == PH_END) begin
                  if (aborting) evt[ST_ABT]  <= 1'b1;
                  else          evt[ST_DONE] <= 1'b1;
                  st <= SQ_IDLE;
               end else if (d_use) begin
                  if (ph == PH_WD) st <= SQ_FETCH;
                  else begin
                     op_r <= d_op; wbyte_r <= d_byte; ack_r <= d_ack;
                     st <= SQ_REQ;
                  end
               end else begin
                  ph <= phase_e'(ph + 4'd1);
               end
            end
            SQ_FETCH: begin
               if (abort_lat) st <= SQ_DECIDE;
               else if (tx_valid) begin
                  op_r <= BOP_WRITE; wbyte_r <= tx_data; ack_r <= 1'b0;
                  st <= SQ_REQ;
               end
            end
            SQ_REQ: if (bus_done) begin
               st <= SQ_DECIDE;
               case (ph)
                  PH_A1, PH_A2: begin
                     if (bus_nack && !f_ign) begin
                        failing <= 1'b1; evt[ST_FAIL] <= 1'b1; ph <= PH_STOP;
                     end else ph <= phase_e'(ph + 4'd1);
                  end
                  PH_WD: begin
                     if (bus_nack) begin
                        failing <= 1'b1; evt[ST_FAIL] <= 1'b1; ph <= PH_STOP;
                     end else wcnt <= wcnt - ONE;
                  end
                  PH_RD: begin
                     rx_valid <= 1'b1; rx_data <= bus_rbyte; rcnt <= rcnt - ONE;
                  end
                  default: ph <= phase_e'(ph + 4'd1);
               endcase
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign tx_ready  = (st == SQ_FETCH) && !abort_lat;
   assign bus_req   = (st == SQ_REQ);
   assign bus_op    = op_r;
   assign bus_wbyte = wbyte_r;
   assign bus_ack   = ack_r;
   assign busy      = (st != SQ_IDLE);

   // R2: request and its operands are held until the engine answers
   p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_done) |=> (bus_req && $stable(bus_op) && $stable(bus_wbyte)));
   // R2: the TX stream is never popped while an operation is outstanding
   p_pop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> !bus_req);
   // R3: final read byte is NACKed unless the ack-last flag is set
   p_last_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_op == BOP_READ && rcnt == ONE && !f_acklast) |-> !bus_ack);
   // R1: an illegal command leaves the sequencer idle
   p_ill_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      evt[ST_ILL] |-> !busy);
   // R13: a command ends either done or aborted, never both
   p_end_once_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt[ST_ABT:ST_DONE]));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
   import i2c_cmd_seq_pkg::*;
#(
   parameter int LEN_W = 8,
   parameter int CMD_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd_word,
   input  logic [LEN_W-1:0] tx_len,
   input  logic [LEN_W-1:0] rx_len,
   input  logic             tx_valid,
   input  logic [7:0]       tx_data,
   output logic             tx_ready,
   output logic             rx_valid,
   output logic [7:0]       rx_data,
   input  logic             abort_req,
   output logic             bus_req,
   output logic [2:0]       bus_op,
   output logic [7:0]       bus_wbyte,
   output logic             bus_ack,
   input  logic             bus_done,
   input  logic [7:0]       bus_rbyte,
   input  logic             bus_nack,
   input  logic [4:0]       sts_clr,
   output logic [4:0]       sts,
   output logic             busy
);
   if (CMD_W < OPC_LSB + 3) begin : g_bad_cmd_w
      $error("CMD_W too narrow for the opcode field");
   end
   if (LEN_W < 1) begin : g_bad_len_w
      $error("LEN_W must be at least 1");
   end

   logic [ST_N-1:0] evt;

   i2c_cmd_fsm #(.LEN_W(LEN_W), .CMD_W(CMD_W)) u_fsm (
      .clk, .rst_n, .cmd_valid, .cmd_word, .tx_len, .rx_len,
      .tx_valid, .tx_data, .tx_ready, .rx_valid, .rx_data, .abort_req,
      .bus_req, .bus_op, .bus_wbyte, .bus_ack, .bus_done, .bus_rbyte,
      .bus_nack, .busy, .evt
   );

   i2c_cmd_sticky #(.N(ST_N)) u_sts (
      .clk, .rst_n, .set(evt), .clr(sts_clr), .q(sts)
   );

   // R11: a command offered while busy lands in the overrun bit
   p_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && busy) |-> ##2 sts[ST_OVR]);
endmodule

// File: tb/i2c_cmd_seq_bench.sv
module i2c_cmd_seq_bench;
   localparam int LEN_W = 4;
   localparam int CMD_W = 19;

   logic clk = 0, rst_n = 0;
   logic cmd_valid = 0;
   logic [CMD_W-1:0] cmd_word = '0;
   logic [LEN_W-1:0] tx_len = '0, rx_len = '0;
   logic tx_valid = 1;
   logic [7:0] tx_data;
   logic tx_ready, rx_valid;
   logic [7:0] rx_data;
   logic abort_req = 0;
   logic bus_req, bus_ack, busy;
   logic [2:0] bus_op;
   logic [7:0] bus_wbyte;
   logic bus_done = 0, bus_nack = 0;
   logic [7:0] bus_rbyte = '0;
   logic [4:0] sts_clr = '0, sts;

   always #2 clk = ~clk;

   i2c_cmd_seq #(.LEN_W(LEN_W), .CMD_W(CMD_W)) u_i2c_cmd_seq (
      .clk, .rst_n, .cmd_valid, .cmd_word, .tx_len, .rx_len, .tx_valid,
      .tx_data, .tx_ready, .rx_valid, .rx_data, .abort_req, .bus_req,
      .bus_op, .bus_wbyte, .bus_ack, .bus_done, .bus_rbyte, .bus_nack,
      .sts_clr, .sts, .busy
   );

   int checks = 0, failures = 0;
   logic [11:0] obs[$], expq[$];
   logic [7:0]  rxo[$], rxe[$];
   logic [7:0]  txbuf[16];
   logic [3:0]  tx_idx = '0;
   int opn = 0, nack_at = -1, abort_at = -1, pend_cnt = 0, done_rises = 0;
   logic pend = 0, last_done = 0;
   logic [7:0] rb = 8'hC0;

   assign tx_data = txbuf[tx_idx];

   always @(posedge clk)
      if (cmd_valid && !busy) tx_idx <= '0;
      else if (tx_ready && tx_valid) tx_idx <= tx_idx + 4'd1;

   // behavioural bit-engine model and monitors
   always @(negedge clk) begin
      abort_req = 1'b0;
      if (rx_valid) rxo.push_back(rx_data);
      if (sts[0] && !last_done) done_rises++;
      last_done = sts[0];
      if (bus_done) begin
         bus_done = 1'b0; pend = 1'b0;
      end else if (bus_req && !pend) begin
         pend = 1'b1; pend_cnt = 2;
         obs.push_back({bus_op, bus_wbyte, bus_ack});
         if (bus_op == 3'd3) begin bus_rbyte = rb; rxe.push_back(rb); rb = rb + 8'd7; end
         bus_nack = (opn == nack_at);
         if (opn == abort_at) abort_req = 1'b1;
         opn++;
      end else if (pend) begin
         if (pend_cnt == 0) bus_done = 1'b1;
         else pend_cnt--;
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(string req, bit ok, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void ex(int op, int b, int a);
      expq.push_back({op[2:0], b[7:0], a[0]});
   endfunction

   task automatic issue(int opc, int prm, int tl, int rl);
      @(negedge clk);
      cmd_word = {opc[2:0], prm[15:0]};
      tx_len = tl[LEN_W-1:0]; rx_len = rl[LEN_W-1:0];
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic finish_cmd(string req, int exp_sts, int clr);
      int n = 0;
      bit ok;
      while (busy && n < 5000) begin @(negedge clk); n++; end
      repeat (4) @(negedge clk);
      ok = (obs.size() == expq.size());
      if (ok) foreach (obs[i]) if (obs[i] !== expq[i]) ok = 0;
      if (!ok) $display("FAIL %s op list mismatch (sizes %0d/%0d)", req, obs.size(), expq.size());
      if (!ok) foreach (obs[i]) $display("   op %0d actual=%0h", i, obs[i]);
      if (!ok) foreach (expq[i]) $display("   op %0d expected=%0h", i, expq[i]);
      chk({req, " ops"}, ok, obs.size(), expq.size());
      ok = (rxo.size() == rxe.size());
      if (ok) foreach (rxo[i]) if (rxo[i] !== rxe[i]) ok = 0;
      chk({req, " rx bytes"}, ok, rxo.size(), rxe.size());
      chk({req, " status"}, sts == exp_sts[4:0], sts, exp_sts);
      // R13: done rises once per completed legal command
      chk({req, " R13 done count"}, done_rises == exp_sts[0], done_rises, exp_sts[0]);
      sts_clr = clr[4:0];
      @(negedge clk);
      sts_clr = '0;
      @(negedge clk);
      chk({req, " R12 clear"}, sts == (exp_sts[4:0] & ~clr[4:0]), sts, exp_sts & ~clr);
      sts_clr = 5'h1F; @(negedge clk); sts_clr = '0; @(negedge clk);
      obs.delete(); expq.delete(); rxo.delete(); rxe.delete();
      opn = 0; nack_at = -1; abort_at = -1; done_rises = 0; last_done = 0;
   endtask

   localparam int A  = 7'h2A;
   localparam int AP = A << 9;
   localparam int AW = 8'h54, AR = 8'h55;

   initial begin
      foreach (txbuf[i]) txbuf[i] = 8'h50 + i;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 reset sts", sts == 5'h0, sts, 0);
      chk("R12 reset idle", !busy && !bus_req && !tx_ready && !rx_valid, busy, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R2: plain write of 3 bytes
      ex(0,0,0); ex(2,AW,0); ex(2,8'h50,0); ex(2,8'h51,0); ex(2,8'h52,0); ex(1,0,0);
      issue(1, AP, 3, 0); finish_cmd("R2 write", 5'h01, 5'h01);

      // R3: read 3, last NACKed
      ex(0,0,0); ex(2,AR,0); ex(3,0,1); ex(3,0,1); ex(3,0,0); ex(1,0,0);
      issue(2, AP, 0, 3); finish_cmd("R3 read", 5'h01, 5'h01);

      // R3: read 2 with ack-last flag (bit 7)
      ex(0,0,0); ex(2,AR,0); ex(3,0,1); ex(3,0,1); ex(1,0,0);
      issue(2, AP | (1<<7), 0, 2); finish_cmd("R3 read ack-last", 5'h01, 5'h01);

      // R4: write 2 then read 1
      ex(0,0,0); ex(2,AW,0); ex(2,8'h50,0); ex(2,8'h51,0); ex(0,0,0); ex(2,AR,0); ex(3,0,0); ex(1,0,0);
      issue(3, AP, 2, 1); finish_cmd("R4 write-read", 5'h01, 5'h01);

      // R5: address only
      ex(0,0,0); ex(2,AW,0); ex(1,0,0);
      issue(4, AP, 0, 0); finish_cmd("R5 addr-only", 5'h01, 5'h01);

      // R6: hold the bus (bit 2), no STOP
      ex(0,0,0); ex(2,AW,0); ex(2,8'h50,0);
      issue(1, AP | (1<<2), 1, 0); finish_cmd("R6 hold", 5'h01, 5'h01);
      // R6: next command opens with START (repeated)
      ex(0,0,0); ex(2,AR,0); ex(3,0,0); ex(1,0,0);
      issue(2, AP, 0, 1); finish_cmd("R6 restart", 5'h01, 5'h01);

      // R9: opcode 7 issues STOP only
      ex(1,0,0);
      issue(7, AP, 0, 0); finish_cmd("R9 stop-only", 5'h01, 5'h01);

      // R7: skip address (bit 8)
      ex(0,0,0); ex(2,8'h50,0); ex(2,8'h51,0); ex(1,0,0);
      issue(1, AP | (1<<8), 2, 0); finish_cmd("R7 no-addr", 5'h01, 5'h01);

      // R8: address NACK -> failure and STOP
      nack_at = 1;
      ex(0,0,0); ex(2,AW,0); ex(1,0,0);
      issue(1, AP, 2, 0); finish_cmd("R8 addr nack", 5'h05, 5'h04);

      // R8: address NACK ignored (bit 6)
      nack_at = 1;
      ex(0,0,0); ex(2,AW,0); ex(2,8'h50,0); ex(1,0,0);
      issue(1, AP | (1<<6), 1, 0); finish_cmd("R8 ignore nack", 5'h01, 5'h01);

      // R8: data NACK -> failure even with bit 6
      nack_at = 2;
      ex(0,0,0); ex(2,AW,0); ex(2,8'h50,0); ex(1,0,0);
      issue(1, AP | (1<<6), 3, 0); finish_cmd("R8 data nack", 5'h05, 5'h05);

      // R9: bus clear ignores hold
      ex(4,0,0); ex(1,0,0);
      issue(6, AP | (1<<2), 0, 0); finish_cmd("R9 bus clear", 5'h01, 5'h01);

      // R1: illegal opcodes 0 and 5
      issue(0, AP, 2, 0); finish_cmd("R1 opcode 0", 5'h08, 5'h08);
      issue(5, AP, 2, 0); finish_cmd("R1 opcode 5", 5'h08, 5'h00);

      // R10: abort during first data byte
      abort_at = 2;
      ex(0,0,0); ex(2,AW,0); ex(2,8'h50,0); ex(1,0,0);
      issue(1, AP, 6, 0); finish_cmd("R10 abort", 5'h02, 5'h02);

      // R11: command offered while busy is dropped
      ex(0,0,0); ex(2,AW,0); ex(2,8'h50,0); ex(2,8'h51,0); ex(1,0,0);
      issue(1, AP, 2, 0);
      repeat (3) @(negedge clk);
      issue(7, 0, 0, 0);
      finish_cmd("R11 overrun", 5'h11, 5'h01);

      // R2: longest write the bench length allows (15)
      ex(0,0,0); ex(2,AW,0);
      for (int i = 0; i < 15; i++) ex(2, 8'h50 + i, 0);
      ex(1,0,0);
      issue(1, AP, 15, 0); finish_cmd("R2 max length", 5'h01, 5'h01);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule